// File: doc/BRIEF.md
# Double-Data-Rate 1:4 Deserializer with Word-Boundary Slip

This block turns a serial bit stream into 4-bit parallel words. Serial bits are sampled on both edges of a fast clock, so the fast clock runs at half the bit rate. Each bit enters a short history shift register. Once per divided-clock cycle, a four-bit window of that history is registered onto the parallel output. The divided clock runs at half the fast clock, which gives one word per divided cycle.

Downstream alignment logic finds the word boundary by pulsing a slip request. Each accepted request moves the window. The moves alternate: the first moves the window one bit older, and the next moves it three bits newer, modulo the word width. A one-bit toggle holds which move comes next. A request is sampled on the divided clock. The new boundary appears on the output two divided-clock cycles after the request is captured. Requests that arrive while a slip is still settling are dropped.

Top module: `deser_bitslip_top`

## Requirements
- R1: While `rst` is high at a rising `clkDiv` edge, `parWord` is 0 after that edge.
- R2: Bits are sampled on falling and rising `clkFast` edges in turn. At a rising `clkDiv` edge, let n be the last bit sampled on the latest rising `clkFast` edge strictly before it. The word then registered is `parWord[i]` = bit (n − off − i). Here `parWord[0]` (Q1) is the newest bit and `parWord[3]` (Q4) the oldest. With no slip, or after reset, off = 2.
- R3: The first accepted slip moves the window one bit older (off 2 → 3). This is a right-by-one rotation.
- R4: The second accepted slip moves the window three bits newer, modulo 4 (off 3 → 0). This is a left-by-three rotation.
- R5: Accepted slips alternate between the two moves, tracked by a one-bit toggle. Over four accepted slips, off takes the values 2, 3, 0, 1 and then returns to 2.
- R6: A `slipReq` high at a `clkDiv` edge E0 is accepted there. The word registered at E0 keeps the old window. The word registered at E1 uses the new one, so the realigned word is first sampled downstream at E2.
- R7: A `slipReq` at either of the two `clkDiv` edges after an accepted slip is ignored. The output window does not change.
- R8: A reset in mid-run restores off = 2 and clears the toggle, so that the next accepted slip acts as a first slip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkFast | input | 1 | Fast bit clock. Data is sampled on both edges. |
| clkDiv | input | 1 | Divided word clock, rising edges aligned to every second rising `clkFast` edge |
| rst | input | 1 | Synchronous reset, active high |
| serialIn | input | 1 | Serial data input |
| slipReq | input | 1 | Single-cycle slip request, sampled on `clkDiv` |
| parWord | output | 4 | Parallel word. Bit 0 is the newest bit, bit 3 the oldest. |

## Verification
Suppose the window offset register drifts or the toggle takes the wrong value. Every later word then shows a stream window shifted by the wrong number of bits. A scoreboard that compares each word with a window cut from its own copy of the serial stream sees this on the first word registered after the bad slip. If the hold counter lets a slip through in its settling window, the offset moves one step too far. That appears on `parWord` one divided cycle after the edge that should have ignored the request. An off-by-one in the fast capture order swaps or displaces bits in every word, so it shows on the first word after reset.

// File: rtl/deser_pkg.sv
package deser_pkg;
  // Strobe bundle from slip control to the word datapath
  typedef struct packed {
    logic accept;    // slip accepted at this divided-clock edge
    logic leftStep;  // 1: move window newer by WORD_W-1, 0: older by one
  } slipCmd_t;
endpackage

// File: rtl/deser_ddr_capture.sv
module deser_ddr_capture #(
  parameter int HIST_W = 7
) (
  input  logic              clkFast,
  input  logic              rst,
  input  logic              serialIn,
  output logic [HIST_W-1:0] histBits
);
  logic fallBit;

  // Falling edge sample: the older bit of each pair
  always_ff @(negedge clkFast) begin
    if (rst) fallBit <= 1'b0;
    else     fallBit <= serialIn;
  end

  // Rising edge: push the pair, newest at bit 0
  always_ff @(posedge clkFast) begin
    if (rst) histBits <= '0;
    else     histBits <= {histBits[HIST_W-3:0], fallBit, serialIn};
  end
endmodule

// File: rtl/deser_slip_ctrl.sv
module deser_slip_ctrl
  import deser_pkg::*;
#(
  parameter int SLIP_LAT = 2
) (
  input  logic     clkDiv,
  input  logic     rst,
  input  logic     slipReq,
  output slipCmd_t cmd,
  output logic     toggleState
);
  localparam int CW = $clog2(SLIP_LAT + 1);

  logic [CW-1:0] holdCnt;
  logic          acceptNow;

  assign acceptNow = slipReq && !rst && (holdCnt == '0);

  always_ff @(posedge clkDiv) begin
    if (rst) begin
      holdCnt     <= '0;
      toggleState <= 1'b0;
    end else if (acceptNow) begin
      holdCnt     <= CW'(SLIP_LAT);
      toggleState <= ~toggleState;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  always_comb begin
    cmd.accept   = acceptNow;
    cmd.leftStep = toggleState;
  end
endmodule

// File: rtl/deser_word_select.sv
module deser_word_select
  import deser_pkg::*;
#(
  parameter int WORD_W = 4,
  parameter int HIST_W = 2 * WORD_W - 1,
  parameter int OFF_W  = $clog2(WORD_W)
) (
  input  logic              clkDiv,
  input  logic              rst,
  input  logic [HIST_W-1:0] histBits,
  input  slipCmd_t          cmd,
  output logic [WORD_W-1:0] parWord,
  output logic [OFF_W-1:0]  curOff
);
  localparam int IDX_W     = $clog2(HIST_W);
  localparam int BASE_OFF  = WORD_W / 2;
  localparam int LEFT_STEP = WORD_W - 1;

  logic [WORD_W-1:0] nextWord;

  // Window offset, moved only by accepted slip strobes
  always_ff @(posedge clkDiv) begin
    if (rst) begin
      curOff <= OFF_W'(BASE_OFF);
    end else if (cmd.accept) begin
      if (cmd.leftStep) curOff <= curOff - OFF_W'(LEFT_STEP);
      else              curOff <= curOff + OFF_W'(1);
    end
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_pick
    logic [IDX_W-1:0] pick;
    assign pick        = IDX_W'(curOff) + IDX_W'(i);
    assign nextWord[i] = histBits[pick];
  end

  always_ff @(posedge clkDiv) begin
    if (rst) parWord <= '0;
    else     parWord <= nextWord;
  end
endmodule

// File: rtl/deser_bitslip_top.sv
module deser_bitslip_top
  import deser_pkg::*;
#(
  parameter int WORD_W   = 4,
  parameter int SLIP_LAT = 2
) (
  input  logic              clkFast,
  input  logic              clkDiv,
  input  logic              rst,
  input  logic              serialIn,
  input  logic              slipReq,
  output logic [WORD_W-1:0] parWord
);
  localparam int HIST_W = 2 * WORD_W - 1;
  localparam int OFF_W  = $clog2(WORD_W);

  logic [HIST_W-1:0] histBits;
  slipCmd_t          slipCmd;
  logic              toggleState;
  logic [OFF_W-1:0]  curOff;

  deser_ddr_capture #(.HIST_W(HIST_W)) u_capture (
    .clkFast (clkFast),
    .rst     (rst),
    .serialIn(serialIn),
    .histBits(histBits)
  );

  deser_slip_ctrl #(.SLIP_LAT(SLIP_LAT)) u_ctrl (
    .clkDiv     (clkDiv),
    .rst        (rst),
    .slipReq    (slipReq),
    .cmd        (slipCmd),
    .toggleState(toggleState)
  );

  deser_word_select #(.WORD_W(WORD_W), .HIST_W(HIST_W), .OFF_W(OFF_W)) u_word (
    .clkDiv  (clkDiv),
    .rst     (rst),
    .histBits(histBits),
    .cmd     (slipCmd),
    .parWord (parWord),
    .curOff  (curOff)
  );
endmodule

// File: rtl/deser_bitslip_checker.sv
module deser_bitslip_checker
  import deser_pkg::*;
#(
  parameter int WORD_W = 4,
  parameter int OFF_W  = $clog2(WORD_W)
) (
  input logic              clkDiv,
  input logic              rst,
  input logic [WORD_W-1:0] parWord,
  input slipCmd_t          slipCmd,
  input logic              toggleState,
  input logic [OFF_W-1:0]  curOff
);
  AST_RESET_ZERO: assert property (@(posedge clkDiv) rst |=> parWord == '0); // R1

  AST_ROTATE_STEP: assert property (@(posedge clkDiv) disable iff (rst)
    slipCmd.accept |=> curOff == OFF_W'($past(curOff) + OFF_W'(1))); // R3

  AST_TOGGLE_FLIP: assert property (@(posedge clkDiv) disable iff (rst)
    slipCmd.accept |=> toggleState != $past(toggleState)); // R5

  AST_OFFSET_HOLD: assert property (@(posedge clkDiv) disable iff (rst)
    !slipCmd.accept |=> $stable(curOff)); // R6

  AST_IGNORE_NEXT: assert property (@(posedge clkDiv) disable iff (rst)
    slipCmd.accept |=> !slipCmd.accept); // R7

  AST_IGNORE_SECOND: assert property (@(posedge clkDiv) disable iff (rst)
    $past(slipCmd.accept, 2) |-> !slipCmd.accept); // R7

  AST_RESET_ALIGN: assert property (@(posedge clkDiv)
    rst |=> (curOff == OFF_W'(WORD_W / 2)) && !toggleState); // R8
endmodule

bind deser_bitslip_top deser_bitslip_checker #(.WORD_W(WORD_W)) u_chk (
  .clkDiv     (clkDiv),
  .rst        (rst),
  .parWord    (parWord),
  .slipCmd    (slipCmd),
  .toggleState(toggleState),
  .curOff     (curOff)
);

// File: tb/tb_deser_bitslip_top.sv
`timescale 1ns/1ps
module tb_deser_bitslip_top;
  logic       clkFast, clkDiv, rst, serialIn, slipReq;
  logic [3:0] parWord;

  int checks = 0;
  int failures = 0;
  int divCount = 0;
  bit finished = 0;

  int         expEdge[$];
  logic [3:0] expVal[$];
  string      expTag[$];

  int mOff = 2;
  int mBusy = 0;
  int skip = 3;
  bit r6Next = 0;

  deser_bitslip_top dut (
    .clkFast(clkFast), .clkDiv(clkDiv), .rst(rst),
    .serialIn(serialIn), .slipReq(slipReq), .parWord(parWord)
  );

  initial begin
    clkFast = 0;
    forever #5 clkFast = ~clkFast;
  end

  // 50 MHz divided clock, rising with every second fast rising edge
  initial begin
    clkDiv = 0;
    #5;
    forever begin
      clkDiv = 1; #10;
      clkDiv = 0; #10;
    end
  end

  always @(posedge clkDiv) divCount++;

  function automatic logic streamBit(int idx);
    int h;
    h = idx * 1103 + 12345;
    h = h ^ (h >>> 5);
    return h[3] ^ h[7];
  endfunction

  // Bit idx is sampled at 10 + 5*idx ns (falling fast edges at even idx)
  initial begin
    serialIn = 0;
    #7.5;
    for (int idx = 0; ; idx++) begin
      serialIn = streamBit(idx);
      #5;
    end
  end

  function automatic logic [3:0] window(int p, int off);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = streamBit(4 * p - 7 - off - i);
    return v;
  endfunction

  task automatic pushExp(int p, logic [3:0] v, string tag);
    expEdge.push_back(p);
    expVal.push_back(v);
    expTag.push_back(tag);
  endtask

  // Driver: sets inputs for the next divided edge and predicts its word
  task automatic cycle(logic slip, logic rstV, string tag);
    int p;
    bit acc;
    @(negedge clkDiv);
    #2.5;
    slipReq = slip;
    rst = rstV;
    p = divCount + 1;
    if (rstV) begin
      pushExp(p, 4'h0, tag);
      mOff = 2; mBusy = 0; skip = 3; r6Next = 0;
    end else begin
      acc = slip && (mBusy == 0);
      if (skip > 0) skip--;
      else pushExp(p, window(p, mOff), (acc || r6Next) ? "R6" : tag);
      r6Next = acc;
      if (acc) begin
        mOff = (mOff + 1) % 4;
        mBusy = 2;
      end else if (mBusy > 0) begin
        mBusy--;
      end
    end
  endtask

  // Monitor: compares each registered word against the scoreboard
  always @(negedge clkDiv) begin
    if (expEdge.size() > 0 && expEdge[0] == divCount) begin
      checks++;
      if (parWord !== expVal[0]) begin
        failures++;
        $display("FAIL %s edge=%0d actual=%h expected=%h",
                 expTag[0], divCount, parWord, expVal[0]);
      end
      void'(expEdge.pop_front());
      void'(expVal.pop_front());
      void'(expTag.pop_front());
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1;
    slipReq = 0;
    repeat (4) @(negedge clkDiv);
    checks++;
    if (parWord !== 4'h0) begin
      failures++;
      $display("FAIL R1 actual=%h expected=0", parWord);
    end

    repeat (8) cycle(0, 0, "R2");            // natural grouping, offset 2
    cycle(1, 0, "R3");                       // right by one
    repeat (5) cycle(0, 0, "R3");
    cycle(1, 0, "R4");                       // left by three
    repeat (5) cycle(0, 0, "R4");
    cycle(1, 0, "R5");
    repeat (5) cycle(0, 0, "R5");
    cycle(1, 0, "R5");                       // back to offset 2
    repeat (5) cycle(0, 0, "R5");

    cycle(1, 0, "R7");                       // accepted
    cycle(0, 0, "R7");
    cycle(1, 0, "R7");                       // in settling window: ignored
    cycle(0, 0, "R7");
    cycle(1, 0, "R7");                       // accepted again
    repeat (5) cycle(0, 0, "R7");

    cycle(1, 0, "R8");
    repeat (3) cycle(0, 0, "R8");
    repeat (2) cycle(0, 1, "R8");            // mid-run reset
    repeat (8) cycle(0, 0, "R8");
    cycle(1, 0, "R8");                       // acts as a first slip
    repeat (5) cycle(0, 0, "R8");

    repeat (3) @(negedge clkDiv);
    checks++;
    if (expEdge.size() != 0) begin
      failures++;
      $display("FAIL R2 pending actual=%0d expected=0", expEdge.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule